// File: doc/BRIEF.md
# Loop Gain Calibration Sequencer

This block runs the loop gain step of a wide-band PLL's open-loop calibration. It starts once the coarse VCO band has been chosen. The block selects a low tune reference and waits a programmable settling time. It then asks the frequency counter for a reading. It repeats the same steps at a high tune reference. The difference between the two counts is the VCO gain, because the voltage step between the two references is fixed.

From that gain and the division ratio, the block computes a charge-pump current code proportional to N divided by the gain. This keeps the product of pump current and VCO gain over N, and so the loop bandwidth, close to constant across bands. A sequential restoring divider produces the code, which is then clamped into the legal non-zero range. At the end the block releases the loop into closed-loop locking.

A gain that is not positive counts as a failed measurement. The block flags it and keeps the starting pump code.

Top module: `lgc_seq`

## Requirements
- R1: After reset, all of these are low: vt_lo_sel, vt_hi_sel, meas_req, loop_close, done and err. cp_code equals INIT_CODE.
- R2: A start pulse seen while idle or finished begins a run. On the next cycle vt_lo_sel is high, cp_code has been reloaded with INIT_CODE, and done, loop_close and err are low.
- R3: Each tune step (low first, then high) holds its select line with meas_req low for exactly settle_len+1 cycles. meas_req then rises while the same select line stays high.
- R4: The first cnt_valid seen while meas_req is high is taken as that step's reading. One cycle after the low reading, vt_hi_sel is high and vt_lo_sel is low. The two select lines are never high together.
- R5: A cnt_valid pulse while meas_req is low has no effect on the stored readings or on the resulting code.
- R6: A start pulse while a run is in progress is ignored, and the run continues without restarting.
- R7: With d = high count − low count > 0, the final cp_code is floor(N·2^SCALE_SH / d), limited as in R8.
- R8: A quotient of 0 gives cp_code 1, and a quotient above 2^CODE_W−1 gives 2^CODE_W−1. cp_code is never 0.
- R9: If d ≤ 0, err goes high and cp_code keeps INIT_CODE. The run still finishes, with done and loop_close high.
- R10: At completion, done and loop_close rise together and stay high until the next accepted start. While they are high, vt_lo_sel, vt_hi_sel and meas_req are all low.
- R11: cp_code changes only when a start is accepted or when a run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Coarse band search finished; begin loop gain calibration |
| div_n | input | N_W | Division ratio N, sampled at start |
| settle_len | input | SET_W | Settling cycles minus one for each tune step |
| cnt_in | input | CNT_W | Frequency count from the counter |
| cnt_valid | input | 1 | Strobe marking cnt_in as a fresh reading |
| vt_lo_sel | output | 1 | Select the low tune reference |
| vt_hi_sel | output | 1 | Select the high tune reference |
| meas_req | output | 1 | Request a frequency reading |
| cp_code | output | CODE_W | Charge-pump current code |
| loop_close | output | 1 | Close the loop for normal locking |
| done | output | 1 | Calibration finished |
| err | output | 1 | Gain measurement not positive |

## Verification
The bench builds the block with CNT_W=8, N_W=6, SCALE_SH=3, SET_W=3, CODE_W=6 and INIT_CODE=21. The 9-bit quotient can then exceed 63 and can also fall to 0, so both clamp limits are hit in one sweep. The sweep covers every N from 0 to 63 against count differences spread from 1 to 149, and every settle length from 0 to 7. These small widths also make zero and negative differences, stray strobes and early starts easy to place at known cycles.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_LO,
        ST_MEAS_LO,
        ST_SET_HI,
        ST_MEAS_HI,
        ST_CHECK,
        ST_DIV,
        ST_DONE
    } lgc_state_e;
endpackage

// File: rtl/lgc_settle.sv
module lgc_settle #(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SET_W-1:0] len,
    output logic             expired
);
    logic [SET_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == len);
        if (!run)
            cnt_d = '0;
        else if (expired)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lgc_div.sv
module lgc_div #(
    parameter int DW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          fin,
    output logic [DW-1:0] quot
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [VW-1:0] rem;
        logic [DW-1:0] quo;
        logic [VW-1:0] dvs;
    } div_s;

    div_s d, q;
    logic [VW:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem, q.quo[DW-1]};
        if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(DW);
            d.rem  = '0;
            d.quo  = dividend;
            d.dvs  = divisor;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = VW'(trial - {1'b0, q.dvs});
                d.quo = {q.quo[DW-2:0], 1'b1};
            end else begin
                d.rem = trial[VW-1:0];
                d.quo = {q.quo[DW-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin  = q.fin;
    assign quot = q.quo;
endmodule

// File: rtl/lgc_seq.sv
module lgc_seq #(
    parameter int CNT_W     = 12,
    parameter int N_W       = 8,
    parameter int SCALE_SH  = 4,
    parameter int SET_W     = 4,
    parameter int CODE_W    = 6,
    parameter int INIT_CODE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_W-1:0]    div_n,
    input  logic [SET_W-1:0]  settle_len,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cnt_valid,
    output logic              vt_lo_sel,
    output logic              vt_hi_sel,
    output logic              meas_req,
    output logic [CODE_W-1:0] cp_code,
    output logic              loop_close,
    output logic              done,
    output logic              err
);
    import lgc_pkg::*;

    localparam int QW       = N_W + SCALE_SH;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef struct packed {
        lgc_state_e        st;
        logic [N_W-1:0]    n;
        logic [CNT_W-1:0]  lo;
        logic [CNT_W-1:0]  hi;
        logic [CODE_W-1:0] code;
        logic              err;
        logic              div_go;
    } seq_s;

    seq_s d, q;

    logic             settle_run, settle_exp;
    logic [CNT_W:0]   diff;
    logic             diff_bad;
    logic [QW-1:0]    dividend, quot;
    logic             div_fin;
    logic [CODE_W-1:0] code_lim;

    assign settle_run = (q.st == ST_SET_LO) || (q.st == ST_SET_HI);

    lgc_settle #(.SET_W(SET_W)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .len     (settle_len),
        .expired (settle_exp)
    );

    assign diff     = {1'b0, q.hi} - {1'b0, q.lo};
    assign diff_bad = diff[CNT_W] || (diff == '0);
    assign dividend = QW'(q.n) << SCALE_SH;

    lgc_div #(.DW(QW), .VW(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (q.div_go),
        .dividend (dividend),
        .divisor  (diff[CNT_W-1:0]),
        .fin      (div_fin),
        .quot     (quot)
    );

    always_comb begin
        if (quot == '0)
            code_lim = CODE_W'(1);
        else if (quot > QW'(CODE_MAX))
            code_lim = CODE_W'(CODE_MAX);
        else
            code_lim = quot[CODE_W-1:0];
    end

    always_comb begin
        d        = q;
        d.div_go = 1'b0;
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st   = ST_SET_LO;
                    d.n    = div_n;
                    d.code = CODE_W'(INIT_CODE);
                    d.err  = 1'b0;
                end
            end
            ST_SET_LO:  if (settle_exp) d.st = ST_MEAS_LO;
            ST_MEAS_LO: begin
                if (cnt_valid) begin
                    d.lo = cnt_in;
                    d.st = ST_SET_HI;
                end
            end
            ST_SET_HI:  if (settle_exp) d.st = ST_MEAS_HI;
            ST_MEAS_HI: begin
                if (cnt_valid) begin
                    d.hi = cnt_in;
                    d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (diff_bad) begin
                    d.err = 1'b1;
                    d.st  = ST_DONE;
                end else begin
                    d.div_go = 1'b1;
                    d.st     = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_fin) begin
                    d.code = code_lim;
                    d.st   = ST_DONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.code <= CODE_W'(INIT_CODE);
        end else begin
            q <= d;
        end
    end

    assign vt_lo_sel  = (q.st == ST_SET_LO) || (q.st == ST_MEAS_LO);
    assign vt_hi_sel  = (q.st == ST_SET_HI) || (q.st == ST_MEAS_HI);
    assign meas_req   = (q.st == ST_MEAS_LO) || (q.st == ST_MEAS_HI);
    assign cp_code    = q.code;
    assign loop_close = (q.st == ST_DONE);
    assign done       = (q.st == ST_DONE);
    assign err        = q.err;
endmodule

// File: rtl/lgc_chk.sv
module lgc_chk #(
    parameter int CODE_W    = 6,
    parameter int INIT_CODE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              vt_lo_sel,
    input logic              vt_hi_sel,
    input logic              meas_req,
    input logic [CODE_W-1:0] cp_code,
    input logic              loop_close,
    input logic              done,
    input logic              err
);
    a_r4_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vt_lo_sel && vt_hi_sel));

    a_r4_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vt_hi_sel) |-> $past(vt_lo_sel));

    a_r2_lo_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vt_lo_sel) |-> $past(start));

    a_r3_req_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |-> (vt_lo_sel || vt_hi_sel));

    a_r8_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cp_code != '0);

    a_r9_err_keeps_init: assert property (@(posedge clk) disable iff (!rst_n)
        (err && done) |-> (cp_code == CODE_W'(INIT_CODE)));

    a_r10_quiet_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        loop_close |-> (!vt_lo_sel && !vt_hi_sel && !meas_req));

    a_r11_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cp_code) |-> (done || $past(start)));
endmodule

bind lgc_seq lgc_chk #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vt_lo_sel  (vt_lo_sel),
    .vt_hi_sel  (vt_hi_sel),
    .meas_req   (meas_req),
    .cp_code    (cp_code),
    .loop_close (loop_close),
    .done       (done),
    .err        (err)
);

// File: tb/sim_lgc_seq.sv
`timescale 1ns/1ps
module sim_lgc_seq;
    localparam int CNT_W = 8, N_W = 6, SH = 3, SET_W = 3, CODE_W = 6, INIT = 21;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cnt_valid = 1'b0;
    logic [N_W-1:0]    div_n = '0;
    logic [SET_W-1:0]  settle_len = '0;
    logic [CNT_W-1:0]  cnt_in = '0;
    logic vt_lo_sel, vt_hi_sel, meas_req, loop_close, done, err;
    logic [CODE_W-1:0] cp_code;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lgc_seq #(.CNT_W(CNT_W), .N_W(N_W), .SCALE_SH(SH), .SET_W(SET_W),
              .CODE_W(CODE_W), .INIT_CODE(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .div_n(div_n),
        .settle_len(settle_len), .cnt_in(cnt_in), .cnt_valid(cnt_valid),
        .vt_lo_sel(vt_lo_sel), .vt_hi_sel(vt_hi_sel), .meas_req(meas_req),
        .cp_code(cp_code), .loop_close(loop_close), .done(done), .err(err));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int exp_code(input int n, input int lo, input int hi);
        int dd, qq;
        dd = hi - lo;
        if (dd <= 0) return INIT;
        qq = (n << SH) / dd;
        if (qq == 0) return 1;
        if (qq > 63) return 63;
        return qq;
    endfunction

    // mode bit0: stray strobe during settle (R5); bit1: start during measurement (R6)
    task automatic run_cal(input int n, input int lo, input int hi, input int st, input int mode);
        int cnt, g;
        div_n = N_W'(n);
        settle_len = SET_W'(st);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(vt_lo_sel && !done && !loop_close && !err, "R2 run begins", vt_lo_sel, 1);
        chk(cp_code == CODE_W'(INIT), "R2 code reload", cp_code, INIT);
        // low step settle
        cnt = 0; g = 0;
        while (!meas_req && g < 50) begin
            if (vt_lo_sel && !vt_hi_sel) cnt++;
            if ((mode & 1) != 0 && cnt == 1) begin
                cnt_valid = 1'b1;
                cnt_in = CNT_W'(lo ^ 8'h5A);
            end
            @(negedge clk);
            cnt_valid = 1'b0;
            g++;
        end
        chk(cnt == st + 1 && vt_lo_sel, "R3 low settle", cnt, st + 1);
        if ((mode & 2) != 0) start = 1'b1;
        cnt_valid = 1'b1;
        cnt_in = CNT_W'(lo);
        @(negedge clk);
        cnt_valid = 1'b0;
        start = 1'b0;
        chk(vt_hi_sel && !vt_lo_sel, "R4 hi after lo", vt_hi_sel, 1);
        if ((mode & 2) != 0) chk(!meas_req && vt_hi_sel, "R6 start ignored", meas_req, 0);
        chk(cp_code == CODE_W'(INIT), "R11 code steady", cp_code, INIT);
        cnt = 0; g = 0;
        while (!meas_req && g < 50) begin
            if (vt_hi_sel && !vt_lo_sel) cnt++;
            if ((mode & 1) != 0 && cnt == 1) begin
                cnt_valid = 1'b1;
                cnt_in = CNT_W'(hi ^ 8'hA5);
            end
            @(negedge clk);
            cnt_valid = 1'b0;
            g++;
        end
        chk(cnt == st + 1 && vt_hi_sel, "R3 high settle", cnt, st + 1);
        cnt_valid = 1'b1;
        cnt_in = CNT_W'(hi);
        @(negedge clk);
        cnt_valid = 1'b0;
        g = 0;
        while (!done && g < 60) begin
            chk(!loop_close && cp_code == CODE_W'(INIT), "R11 no early change", cp_code, INIT);
            @(negedge clk);
            g++;
        end
        chk(int'(cp_code) == exp_code(n, lo, hi), (hi - lo <= 0) ? "R9 code kept" :
            "R7 R8 code", cp_code, exp_code(n, lo, hi));
        chk(err == (hi - lo <= 0), "R9 err flag", err, (hi - lo <= 0));
        chk(done && loop_close && !vt_lo_sel && !vt_hi_sel && !meas_req,
            "R10 released", loop_close, 1);
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!vt_lo_sel && !vt_hi_sel && !meas_req && !loop_close && !done && !err,
            "R1 reset outputs", done, 0);
        chk(cp_code == CODE_W'(INIT), "R1 reset code", cp_code, INIT);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 stray strobe while idle has no effect
        cnt_valid = 1'b1; cnt_in = 8'hFF;
        @(negedge clk);
        cnt_valid = 1'b0;
        chk(!vt_lo_sel && !done, "R5 idle strobe", done, 0);
        // directed corner cases
        run_cal(10, 50, 50, 2, 0);   // R9 zero difference
        run_cal(10, 90, 40, 0, 0);   // R9 negative difference
        run_cal(63, 10, 11, 1, 0);   // R8 upper clamp
        run_cal(1, 0, 200, 3, 0);    // R8 lower clamp
        run_cal(40, 20, 60, 4, 1);   // R5 stray strobes in settle
        run_cal(25, 5, 30, 2, 2);    // R6 start mid-run
        run_cal(0, 5, 30, 0, 0);     // R8 N = 0
        // R10 release holds while idle
        repeat (5) @(negedge clk);
        chk(done && loop_close, "R10 held", done, 1);
        // sweep
        for (int n = 0; n < 64; n++) begin
            for (int dd = 1; dd < 150; dd += 4) begin
                run_cal(n, (n * 7) % 100, (n * 7) % 100 + dd, (n + dd) % 8, (n + dd) % 4);
            end
        end
        summary();
    end
endmodule